// File: doc/BRIEF.md
# Pseudo-Hadamard Diffusion Network

This block is the linear mixing stage of a byte-oriented block cipher round. It takes a 16-byte state and passes it through four layers of two-input Pseudo-Hadamard boxes. A fixed byte shuffle sits between each pair of successive layers. Each box turns a byte pair (a, b) into (2a + b, a + b) modulo 256. The doubling is a plain one-bit left shift made by wiring, and the carry out of the top bit is dropped.

The network itself is purely combinational. By default a single output register stage follows it. That register is loaded only when the input-valid flag is high. A valid flag travels with the data and comes out one cycle later. Setting `REG_OUT` to 0 removes the register, and the output then follows the input in the same cycle. Key mixing, nonlinear substitution and round sequencing belong to neighbouring logic.

Byte position 0 is the leftmost byte, bits [127:120]. Position 15 is bits [7:0].

Top module: `pht_diffuse`

## Requirements
- R1: Each box maps the byte pair (a, b) to (2a + b, a + b) modulo 256. 2a is formed as {a[6:0], 1'b0}, so bit 7 of a is discarded.
- R2: In every layer, byte positions 2k and 2k+1 (k = 0..7) feed one box, with a taken from position 2k and b from position 2k+1. The box writes 2a + b back to position 2k and a + b to position 2k+1. Position 0 is bits [127:120].
- R3: Each shuffle moves the byte at input position i to output position P[i]. For i = 0..15, P is 8, 11, 12, 15, 2, 1, 6, 5, 10, 9, 14, 13, 0, 7, 4, 3.
- R4: The data passes through four box layers with a shuffle between consecutive layers: three shuffles in total, and none after the last layer.
- R5: With `REG_OUT`=1, when `in_vld` is high at a rising clock edge, `out_data` shows the network result of that cycle's `in_data` from that edge onward. `out_vld` equals the `in_vld` value sampled at the previous edge.
- R6: When `in_vld` is low at a rising edge, `out_data` keeps its value and ignores `in_data`.
- R7: While `rst_n` is low, `out_data` reads all zeros and `out_vld` reads 0.
- R8: The network is invertible. An all-zero input gives an all-zero output, and any nonzero input gives a nonzero output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input state is valid; loads the output register |
| in_data | input | 128 | Input state, byte 0 in bits [127:120] |
| out_vld | output | 1 | Registered copy of `in_vld` |
| out_data | output | 128 | Diffused state |

## Verification
Two events can fall in the same cycle:
- A new state is loaded while the result of the previous state is still being presented. The bench provokes this by driving a valid random state on every cycle, back to back, and checks each output against a bench reference model one cycle after its input.
- Reset is asserted while `in_vld` is high. The bench provokes this by pulling reset low in the middle of a valid stream. The cleared output then has to win over the pending load.

Each single box is also checked exhaustively over all 65536 input pairs.

// File: rtl/pht_pkg.sv
package pht_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_BYTES  = 16;
    localparam int N_LAYERS = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // Destination position of byte src in one inter-layer shuffle (R3)
    function automatic int shuffle_dest(input int src);
        int d;
        case (src)
            0:  d = 8;
            1:  d = 11;
            2:  d = 12;
            3:  d = 15;
            4:  d = 2;
            5:  d = 1;
            6:  d = 6;
            7:  d = 5;
            8:  d = 10;
            9:  d = 9;
            10: d = 14;
            11: d = 13;
            12: d = 0;
            13: d = 7;
            14: d = 4;
            15: d = 3;
            default: d = src;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pht_box.sv
module pht_box #(
    parameter int W = pht_pkg::BYTE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_dbl,
    output logic [W-1:0] sum_one
);
    // doubling by wiring: top bit falls off (R1)
    logic [W-1:0] a_x2;
    assign a_x2    = {a[W-2:0], 1'b0};
    assign sum_dbl = a_x2 + b;
    assign sum_one = a + b;
endmodule

// File: rtl/pht_layer.sv
module pht_layer #(
    parameter int W  = pht_pkg::BYTE_W,
    parameter int NB = pht_pkg::N_BYTES
) (
    input  logic [NB*W-1:0] din,
    output logic [NB*W-1:0] dout
);
    localparam int N_PAIRS = NB / 2;

    // position p lives at bits [(NB-1-p)*W +: W] (R2)
    for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
        localparam int LO_POS = 2 * k;
        localparam int HI_POS = 2 * k + 1;
        pht_box #(.W(W)) u_box (
            .a       (din [(NB-1-LO_POS)*W +: W]),
            .b       (din [(NB-1-HI_POS)*W +: W]),
            .sum_dbl (dout[(NB-1-LO_POS)*W +: W]),
            .sum_one (dout[(NB-1-HI_POS)*W +: W])
        );
    end
endmodule

// File: rtl/pht_shuffle.sv
module pht_shuffle #(
    parameter int W  = pht_pkg::BYTE_W,
    parameter int NB = pht_pkg::N_BYTES
) (
    input  logic [NB*W-1:0] din,
    output logic [NB*W-1:0] dout
);
    for (genvar i = 0; i < NB; i++) begin : g_move
        localparam int DST = pht_pkg::shuffle_dest(i);
        assign dout[(NB-1-DST)*W +: W] = din[(NB-1-i)*W +: W];
    end
endmodule

// File: rtl/pht_diffuse.sv
module pht_diffuse #(
    parameter int W       = pht_pkg::BYTE_W,
    parameter int NB      = pht_pkg::N_BYTES,
    parameter int LAYERS  = pht_pkg::N_LAYERS,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [NB*W-1:0] in_data,
    output logic            out_vld,
    output logic [NB*W-1:0] out_data
);
    localparam int STATE_W = NB * W;

    logic [STATE_W-1:0] stage_in  [LAYERS+1];
    logic [STATE_W-1:0] stage_mix [LAYERS];
    logic [STATE_W-1:0] net_out;

    assign stage_in[0] = in_data;

    // box layers joined by shuffles, none after the last (R4)
    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        pht_layer #(.W(W), .NB(NB)) u_layer (
            .din  (stage_in[l]),
            .dout (stage_mix[l])
        );
        if (l < LAYERS - 1) begin : g_shf
            pht_shuffle #(.W(W), .NB(NB)) u_shf (
                .din  (stage_mix[l]),
                .dout (stage_in[l+1])
            );
        end else begin : g_last
            assign stage_in[l+1] = stage_mix[l];
        end
    end

    assign net_out = stage_in[LAYERS];

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_vld  <= 1'b0;
                out_data <= '0;
            end else begin
                out_vld <= in_vld;
                if (in_vld) out_data <= net_out;
            end
        end
    end else begin : g_comb
        assign out_vld  = in_vld;
        assign out_data = net_out;
    end
endmodule

// File: rtl/pht_diffuse_chk.sv
module pht_diffuse_chk #(
    parameter int W       = 8,
    parameter int NB      = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [NB*W-1:0] in_data,
    input logic            out_vld,
    input logic [NB*W-1:0] out_data
);
    if (REG_OUT) begin : g_props
        // R5
        vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_vld == $past(in_vld)));

        // R6
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_vld)) |-> $stable(out_data));

        // R7
        reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (!out_vld && out_data == '0));

        // R8
        zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_vld) && $past(in_data) == '0) |-> (out_data == '0));

        // R8
        nonzero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_vld) && $past(in_data) != '0) |-> (out_data != '0));
    end
endmodule

bind pht_diffuse pht_diffuse_chk #(.W(W), .NB(NB), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data)
);

// File: tb/sim_pht_diffuse.sv
`timescale 1ns/1ps
module sim_pht_diffuse;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [127:0] in_data = '0;
    logic         out_vld;
    logic [127:0] out_data;

    logic [7:0]   bx_a, bx_b, bx_d, bx_s;
    logic [127:0] sh_in, sh_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    pht_diffuse u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
                    .out_vld(out_vld), .out_data(out_data));
    pht_box     u_box (.a(bx_a), .b(bx_b), .sum_dbl(bx_d), .sum_one(bx_s));
    pht_shuffle u_shf (.din(sh_in), .dout(sh_out));

    int dst_tab [16] = '{8, 11, 12, 15, 2, 1, 6, 5, 10, 9, 14, 13, 0, 7, 4, 3};

    function automatic logic [127:0] ref_net(input logic [127:0] x);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [127:0] r;
        for (int i = 0; i < 16; i++) s[i] = x[127-8*i -: 8];
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] a, b;
                a = s[2*k]; b = s[2*k+1];
                s[2*k]   = 8'((2 * int'(a) + int'(b)) % 256);
                s[2*k+1] = 8'((int'(a) + int'(b)) % 256);
            end
            if (l < 3) begin
                for (int i = 0; i < 16; i++) t[dst_tab[i]] = s[i];
                for (int i = 0; i < 16; i++) s[i] = t[i];
            end
        end
        for (int i = 0; i < 16; i++) r[127-8*i -: 8] = s[i];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rand128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] prev, held, x;
        void'($urandom(32'h5EED_0017));

        // R1: every box input pair
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                bx_a = 8'(a); bx_b = 8'(b);
                #1;
                check(bx_d == 8'((2*a + b) % 256) && bx_s == 8'((a + b) % 256), "R1 box",
                      {112'd0, bx_d, bx_s},
                      {112'd0, 8'((2*a + b) % 256), 8'((a + b) % 256)});
            end
        end

        // R3: shuffle with labelled bytes
        for (int i = 0; i < 16; i++) sh_in[127-8*i -: 8] = 8'(i);
        #1;
        for (int i = 0; i < 16; i++)
            check(sh_out[127-8*dst_tab[i] -: 8] == 8'(i), "R3 shuffle",
                  {120'd0, sh_out[127-8*dst_tab[i] -: 8]}, 128'(i));

        // R7: reset state
        in_vld = 1'b1; in_data = rand128();
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0 && out_data == '0, "R7 reset", out_data, '0);
        @(negedge clk); rst_n = 1'b1;
        in_vld = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0 && out_data == '0, "R7 after release", out_data, '0);

        // R2/R4/R5: directed patterns, each byte alone, then all ones
        for (int p = 0; p < 16; p++) begin
            x = '0; x[127-8*p -: 8] = 8'h01;
            in_vld = 1'b1; in_data = x;
            @(negedge clk);
            check(out_data == ref_net(x) && out_vld, "R2 R4 single byte", out_data, ref_net(x));
        end
        x = '1; in_data = x;
        @(negedge clk);
        check(out_data == ref_net(x), "R4 all ones", out_data, ref_net(x));

        // R8: zero in, zero out
        in_data = '0;
        @(negedge clk);
        check(out_data == '0, "R8 zero", out_data, '0);

        // R5: back-to-back random states
        for (int n = 0; n < 400; n++) begin
            x = rand128(); in_vld = 1'b1; in_data = x;
            @(negedge clk);
            check(out_vld && out_data == ref_net(x), "R5 stream", out_data, ref_net(x));
        end

        // R6: idle cycles ignore input
        held = out_data;
        for (int n = 0; n < 20; n++) begin
            in_vld = 1'b0; in_data = rand128();
            @(negedge clk);
            check(!out_vld && out_data == held, "R6 hold", out_data, held);
        end

        // R5/R6: random valid gaps
        prev = held;
        for (int n = 0; n < 300; n++) begin
            x = rand128(); in_vld = ($urandom % 3) != 0; in_data = x;
            if (in_vld) prev = ref_net(x);
            @(negedge clk);
            check(out_vld == in_vld && out_data == prev, "R5 R6 gapped", out_data, prev);
        end

        // R7: reset while a valid state is presented
        in_vld = 1'b1; in_data = rand128(); rst_n = 1'b0;
        @(negedge clk);
        check(!out_vld && out_data == '0, "R7 reset over load", out_data, '0);
        rst_n = 1'b1; x = rand128(); in_data = x;
        @(negedge clk);
        check(out_vld && out_data == ref_net(x), "R5 after reset", out_data, ref_net(x));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule